// File: doc/BRIEF.md
# Synthesizer Serial Programming Sequencer

This block is the host-side controller for a frequency synthesizer that takes its settings over a three-wire serial port: data, clock and load enable. As soon as reset is released, it programs all four of the synthesizer's 24-bit latches, with no request needed. It sends an initialization word, then a function word, then a reference word, and last an N-divider word that tunes the synthesizer to channel 0. The reference word and the function word come from input buses. The initialization word is the function word with different control bits.

After that, the host retunes with a request/busy/done handshake and a channel index. The block turns the channel into a total divide ratio `N = N_BASE + channel`. It then splits N into a B count (`N >> PRESC_LOG2`) and an A count (`N mod 2**PRESC_LOG2`), which suits a dual-modulus prescaler. The resulting N word is the only word it sends. A channel index above `MAX_CH` gives a one-cycle error pulse, and nothing is sent for it. The serial clock period is set by the parameter `DIV`.

Top module: `synth_prog_seq`

## Requirements
- R1: After reset is released, the block sends four words with no request, in this order: initialization, function, reference, N. `busy` is high for the whole startup sequence, and `done` pulses once at its end.
- R2: The control bits (1..0) of the startup words are forced: the initialization word is `cfg_func[23:2]` followed by `11`, the function word is `cfg_func[23:2]` followed by `10`, and the reference word is `cfg_ref[23:2]` followed by `00`.
- R3: The N word sent at startup is the word for channel 0. With the default parameters this is 0x003401.
- R4: N word layout: bits 1..0 = `01`, bits 7..2 = A count, bits 20..8 = B count, bits 23..21 = 0. Here N = 1664 + channel, B = N/32 and A = N mod 32. For example, channel 31 gives 0x00347D, channel 32 gives 0x003501 and channel 88 gives 0x003661.
- R5: A request accepted while idle with a valid channel (0..88) sends exactly one word, the N word.
- R6: A request with a channel above 88 gives `err` high for exactly one cycle, in the cycle after the request. `busy` stays low and nothing is sent.
- R7: Words are sent MSB first, 24 clock pulses per word. `ser_data` changes only while `ser_clk` is low. `ser_clk` is high for `DIV` cycles and low for `DIV` cycles per bit.
- R8: After bit 0, `ser_le` is high for exactly 2*`DIV` cycles, and `ser_clk` is low during that time.
- R9: `busy` rises in the cycle after an accepted request. It falls in the same cycle that `ser_le` of the last word falls. `done` is high for exactly that one cycle.
- R10: A request made while `busy` is high is ignored. Only the word of the accepted request is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Retune request, sampled while idle |
| chan | input | 7 | Channel index for the request |
| cfg_ref | input | 24 | Reference latch word (control bits replaced) |
| cfg_func | input | 24 | Function latch word (control bits replaced) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| err | output | 1 | One-cycle pulse for a rejected channel |
| ser_data | output | 1 | Serial data, MSB first |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_le | output | 1 | Load enable pulse after the last bit |

## Verification
The assertions assume that reset is released only once, and that requests are single-cycle pulses aligned to `clk`. They also assume that `cfg_ref` and `cfg_func` stay constant from reset through the end of the startup sequence, because the block samples them when each word starts. The stimulus sets both configuration buses before reset is released and never changes them. It drives `req` and `chan` only on falling clock edges, holds `req` for one cycle, and raises a second request only in the middle of a transfer, to test that it is ignored.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int WORD_W = 24;
    localparam int CTRL_W = 2;
    localparam int BCNT_W = 13;
    localparam int ACNT_W = 6;
    localparam int PAD_W  = WORD_W - BCNT_W - ACNT_W - CTRL_W;

    // Latch select codes carried in the two low bits of each word
    typedef enum logic [CTRL_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_NDIV = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } latch_sel_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SHIFT,
        SH_LOAD
    } shift_st_e;

    typedef enum logic [1:0] {
        SQ_ISSUE,
        SQ_WAIT,
        SQ_IDLE
    } seq_st_e;

endpackage

// File: rtl/nword_calc.sv
module nword_calc
    import synth_prog_pkg::*;
#(
    parameter int CHAN_W     = 7,
    parameter int N_BASE     = 1664,
    parameter int PRESC_LOG2 = 5
) (
    input  logic [CHAN_W-1:0] chan_idx,
    output logic [WORD_W-1:0] nword
);
    localparam int NW = 16;
    localparam logic [NW-1:0] BASE_V = NW'(N_BASE);
    localparam logic [NW-1:0] A_MASK = NW'((1 << PRESC_LOG2) - 1);

    logic [NW-1:0]     ratio;
    logic [BCNT_W-1:0] bcnt;
    logic [ACNT_W-1:0] acnt;

    always_comb begin
        ratio = BASE_V + NW'(chan_idx);
        bcnt  = BCNT_W'(ratio >> PRESC_LOG2);
        acnt  = ACNT_W'(ratio & A_MASK);
        nword = {{PAD_W{1'b0}}, bcnt, acnt, SEL_NDIV};
    end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
    import synth_prog_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              fin,
    output logic              sdata,
    output logic              sclk,
    output logic              sle
);
    localparam int CNT_W = $clog2(2 * DIV);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * DIV - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DIV);

    typedef struct packed {
        shift_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [WORD_W-1:0] sr;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        fin  = 1'b0;
        case (sh_q.st)
            SH_IDLE: begin
                if (start) begin
                    sh_d.st   = SH_SHIFT;
                    sh_d.cnt  = '0;
                    sh_d.bitn = BIT_W'(WORD_W - 1);
                    sh_d.sr   = word;
                end
            end
            SH_SHIFT: begin
                if (sh_q.cnt == CNT_LAST) begin
                    sh_d.cnt = '0;
                    if (sh_q.bitn == '0) begin
                        sh_d.st = SH_LOAD;
                    end else begin
                        sh_d.bitn = sh_q.bitn - 1'b1;
                        sh_d.sr   = {sh_q.sr[WORD_W-2:0], 1'b0};
                    end
                end else begin
                    sh_d.cnt = sh_q.cnt + 1'b1;
                end
            end
            SH_LOAD: begin
                if (sh_q.cnt == CNT_LAST) begin
                    sh_d.st  = SH_IDLE;
                    sh_d.cnt = '0;
                    fin      = 1'b1;
                end else begin
                    sh_d.cnt = sh_q.cnt + 1'b1;
                end
            end
            default: sh_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '{st: SH_IDLE, cnt: '0, bitn: '0, sr: '0};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdata = (sh_q.st == SH_SHIFT) && sh_q.sr[WORD_W-1];
    assign sclk  = (sh_q.st == SH_SHIFT) && (sh_q.cnt >= CNT_HALF);
    assign sle   = (sh_q.st == SH_LOAD);

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    // R8
    le_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sle |-> !sclk);

    // R8
    fin_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> sle);

endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
    import synth_prog_pkg::*;
#(
    parameter int DIV        = 2,
    parameter int CHAN_W     = 7,
    parameter int MAX_CH     = 88,
    parameter int N_BASE     = 1664,
    parameter int PRESC_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [CHAN_W-1:0] chan,
    input  logic [WORD_W-1:0] cfg_ref,
    input  logic [WORD_W-1:0] cfg_func,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_le
);
    localparam logic [CHAN_W-1:0] CH_LIMIT = CHAN_W'(MAX_CH);
    localparam logic [1:0]        PH_NDIV  = 2'd3;

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        phase;
        logic [CHAN_W-1:0] chan;
        logic              done;
        logic              err;
    } seq_t;

    seq_t sq_d, sq_q;

    logic              sh_start;
    logic              sh_fin;
    logic [WORD_W-1:0] tx_word;
    logic [WORD_W-1:0] ndiv_word;

    nword_calc #(
        .CHAN_W     (CHAN_W),
        .N_BASE     (N_BASE),
        .PRESC_LOG2 (PRESC_LOG2)
    ) u_calc (
        .chan_idx (sq_q.chan),
        .nword    (ndiv_word)
    );

    always_comb begin
        case (sq_q.phase)
            2'd0:    tx_word = {cfg_func[WORD_W-1:CTRL_W], SEL_INIT};
            2'd1:    tx_word = {cfg_func[WORD_W-1:CTRL_W], SEL_FUNC};
            2'd2:    tx_word = {cfg_ref[WORD_W-1:CTRL_W], SEL_REF};
            default: tx_word = ndiv_word;
        endcase
    end

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        sq_d.err  = 1'b0;
        sh_start  = 1'b0;
        case (sq_q.st)
            SQ_ISSUE: begin
                sh_start = 1'b1;
                sq_d.st  = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (sh_fin) begin
                    if (sq_q.phase == PH_NDIV) begin
                        sq_d.st   = SQ_IDLE;
                        sq_d.done = 1'b1;
                    end else begin
                        sq_d.phase = sq_q.phase + 1'b1;
                        sq_d.st    = SQ_ISSUE;
                    end
                end
            end
            SQ_IDLE: begin
                if (req) begin
                    if (chan <= CH_LIMIT) begin
                        sq_d.chan  = chan;
                        sq_d.phase = PH_NDIV;
                        sq_d.st    = SQ_ISSUE;
                    end else begin
                        sq_d.err = 1'b1;
                    end
                end
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_ISSUE, phase: 2'd0, chan: '0, done: 1'b0, err: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    ser_shifter #(
        .DIV (DIV)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .word  (tx_word),
        .fin   (sh_fin),
        .sdata (ser_data),
        .sclk  (ser_clk),
        .sle   (ser_le)
    );

    assign busy = (sq_q.st != SQ_IDLE);
    assign done = sq_q.done;
    assign err  = sq_q.err;

    // R9
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R6
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    // R9
    le_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_le |-> busy);

    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

endmodule

// File: tb/sim_synth_prog_seq.sv
module sim_synth_prog_seq;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [6:0]  chan = '0;
    logic [23:0] cfg_ref = 24'h000010;
    logic [23:0] cfg_func = 24'h9F8083;
    logic        busy, done, err, ser_data, ser_clk, ser_le;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    synth_prog_seq #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .chan(chan),
        .cfg_ref(cfg_ref), .cfg_func(cfg_func),
        .busy(busy), .done(done), .err(err),
        .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le)
    );

    // serial capture
    logic [23:0] cap_sr = '0;
    int          cap_bits = 0;
    int          bits_base = 0;
    int          last_bits = 0;
    logic [23:0] cap_w [0:15];
    int          cap_n = 0;

    always @(posedge ser_clk) begin
        cap_sr = {cap_sr[22:0], ser_data};
        cap_bits++;
    end

    always @(posedge ser_le) begin
        if (cap_n < 16) cap_w[cap_n] = cap_sr;
        last_bits = cap_bits - bits_base;
        bits_base = cap_bits;
        cap_n++;
    end

    // pulse width monitor
    int le_run = 0, le_last = 0, ck_run = 0, ck_last = 0;
    always @(negedge clk) begin
        if (ser_le) le_run++;
        else if (le_run > 0) begin le_last = le_run; le_run = 0; end
        if (ser_clk) ck_run++;
        else if (ck_run > 0) begin ck_last = ck_run; ck_run = 0; end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(output bit le_before);
        bit prev = 1'b0;
        forever begin
            @(negedge clk);
            if (done) break;
            prev = ser_le;
        end
        le_before = prev;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(!ser_clk && !ser_le && !done && !err, "R1 reset outputs quiet",
              {ser_clk, ser_le, done, err}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_boot;
        bit lb;
        int base = cap_n;
        @(negedge clk);
        check(busy, "R1 busy during startup", busy, 1);
        wait_done(lb);
        check(!busy, "R9 busy low with done", busy, 0);
        check(cap_n - base == 4, "R1 startup word count", cap_n - base, 4);
        check(cap_w[base] == 24'h9F8083, "R2 init word", cap_w[base], 24'h9F8083);
        check(cap_w[base+1] == 24'h9F8082, "R2 function word", cap_w[base+1], 24'h9F8082);
        check(cap_w[base+2] == 24'h000010, "R2 reference word", cap_w[base+2], 24'h000010);
        check(cap_w[base+3] == 24'h003401, "R3 startup N word", cap_w[base+3], 24'h003401);
        check(lb && !ser_le, "R9 done as load enable ends", {lb, ser_le}, 2'b10);
        @(negedge clk);
        check(!done, "R1 done single pulse", done, 0);
    endtask

    task automatic t_chan(input int ch, input logic [23:0] exp);
        bit lb;
        int base = cap_n;
        req = 1'b1; chan = 7'(ch);
        @(negedge clk);
        req = 1'b0;
        check(busy, "R9 busy after request", busy, 1);
        wait_done(lb);
        check(cap_n - base == 1, "R5 single word sent", cap_n - base, 1);
        check(cap_w[base] == exp, "R4 N word value", cap_w[base], exp);
        check(last_bits == 24, "R7 bits per word", last_bits, 24);
        check(lb && !ser_le && !busy, "R9 busy ends with load enable", {lb, ser_le, busy}, 3'b100);
        @(negedge clk);
        check(!done, "R9 done single pulse", done, 0);
    endtask

    task automatic t_bad(input int ch);
        int base = cap_n;
        req = 1'b1; chan = 7'(ch);
        @(negedge clk);
        req = 1'b0;
        check(err && !busy, "R6 error pulse, not busy", {err, busy}, 2'b10);
        @(negedge clk);
        check(!err, "R6 error one cycle", err, 0);
        repeat (200) @(negedge clk);
        check(cap_n == base && !busy, "R6 nothing sent", cap_n - base, 0);
    endtask

    task automatic t_busy_req;
        bit lb;
        int base = cap_n;
        req = 1'b1; chan = 7'd5;
        @(negedge clk);
        req = 1'b0;
        repeat (20) @(negedge clk);
        req = 1'b1; chan = 7'd88;
        @(negedge clk);
        req = 1'b0;
        wait_done(lb);
        repeat (150) @(negedge clk);
        check(cap_n - base == 1, "R10 one word only", cap_n - base, 1);
        check(cap_w[base] == 24'h003415, "R10 first request kept", cap_w[base], 24'h003415);
        check(!busy, "R10 idle afterwards", busy, 0);
    endtask

    task automatic t_timing;
        check(le_last == 2 * DIV, "R8 load enable width", le_last, 2 * DIV);
        check(ck_last == DIV, "R7 serial clock high time", ck_last, DIV);
    endtask

    initial begin
        t_reset;
        t_boot;
        t_timing;
        t_chan(0, 24'h003401);
        t_chan(1, 24'h003405);
        t_chan(31, 24'h00347D);
        t_chan(32, 24'h003501);
        t_chan(88, 24'h003661);
        t_bad(89);
        t_bad(127);
        t_busy_req;
        t_timing;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule